// File: doc/BRIEF.md
# Vectored Per-Line Interrupt Arbiter

This block gathers interrupt requests from the lines of a terminal multiplexer. It keeps them in two separate groups, one for receive and one for transmit. Each group holds one pending bit per line. Per-line set and clear strobes from the register interface write those bits. Each group drives a master request that is high whenever any of its lines is pending.

When the bus acknowledges a group, that group picks its lowest-numbered pending line and clears that line's bit in the same cycle. One cycle later it presents an interrupt vector on a registered output. The vector is computed from a base parameter, with the lines spaced 8 apart and the transmit vectors 4 above the matching receive vectors. An acknowledge that finds nothing pending returns vector zero.

Each group is run by a two-state machine. `ST_IDLE` is the waiting state. `ST_GIVE` is the one-cycle state in which the vector is valid. The transition `ST_IDLE -> ST_GIVE` happens on an acknowledge. `ST_GIVE -> ST_GIVE` happens when another acknowledge arrives back to back. `ST_GIVE -> ST_IDLE` happens when no acknowledge arrives. Reset puts both machines in `ST_IDLE`.

Top module: `vec_irq_arbiter`

## Requirements
- R1: A set strobe for a line makes that line pending, and the group's request output is high from the cycle after the strobe.
- R2: A clear strobe makes its line not pending. When a set and a clear for the same line arrive in the same cycle, the clear wins and the line is not pending afterwards.
- R3: A group's request output is the OR of its pending bits. It stays high after an acknowledge while other lines of the group are still pending.
- R4: An acknowledge selects the lowest-numbered pending line and clears only that line's bit.
- R5: The receive vector for line n is BASE + 8*n.
- R6: The transmit vector for line n is BASE + 8*n + 4.
- R7: An acknowledge when no line of the group is pending returns vector 0.
- R8: The vector output is registered. Its valid flag is high in exactly the cycle after each acknowledge and low otherwise.
- R9: Set strobes for other lines that arrive in the same cycle as an acknowledge are kept as pending.
- R10: The receive and transmit groups are independent. Strobes and acknowledges for one group leave the other group unchanged.
- R11: After reset, no line is pending, both requests are low, both valid flags are low and both vectors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | LINES | Receive per-line set strobes |
| rx_clr | input | LINES | Receive per-line clear strobes |
| rx_ack | input | 1 | Bus acknowledge for the receive group |
| tx_set | input | LINES | Transmit per-line set strobes |
| tx_clr | input | LINES | Transmit per-line clear strobes |
| tx_ack | input | 1 | Bus acknowledge for the transmit group |
| rx_req | output | 1 | Receive master request |
| rx_vec | output | VEC_W | Registered receive vector |
| rx_vec_ok | output | 1 | Receive vector valid |
| tx_req | output | 1 | Transmit master request |
| tx_vec | output | VEC_W | Registered transmit vector |
| tx_vec_ok | output | 1 | Transmit vector valid |

## Verification
The selection is tried with several pending patterns: a single low line, a single top line, all lines, and sparse pairs with gaps. Together these separate a true lowest-first choice from a highest-first choice and from an off-by-one index, and they show the stride of 8 across the whole range. Back-to-back acknowledges drain a group while new sets arrive, which shows that exactly one bit is removed per acknowledge and that concurrent sets survive. The corner cases are an acknowledge on an empty group, a set and a clear colliding on the same line, and traffic confined to one group.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_GIVE = 1'b1
    } ack_state_e;
endpackage

// File: rtl/vec_irq_prio.sv
module vec_irq_prio #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vec_irq_group.sv
module vec_irq_group
    import vec_irq_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int VEC_W  = 9,
    parameter int BASE   = 256,
    parameter int OFFSET = 0,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_i,
    input  logic [LINES-1:0] clr_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_ok_o
);
    ack_state_e       state_q, state_d;
    logic [LINES-1:0] pend_q, pend_d, take;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic [VEC_W-1:0] vec_q, vec_d;

    vec_irq_prio #(.LINES(LINES)) u_prio (
        .pend (pend_q),
        .idx  (win_idx),
        .any  (win_any)
    );

    always_comb begin
        take = '0;
        if (ack_i && win_any) take[win_idx] = 1'b1;
        pend_d = (pend_q | set_i) & ~clr_i & ~take;
        vec_d  = vec_q;
        if (ack_i) begin
            vec_d = win_any ? (VEC_W'(BASE) + VEC_W'({win_idx, 3'b000}) + VEC_W'(OFFSET))
                            : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = ack_i ? ST_GIVE : ST_IDLE;
            ST_GIVE: state_d = ack_i ? ST_GIVE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            vec_q   <= vec_d;
        end
    end

    always_comb begin
        req_o    = |pend_q;
        vec_o    = vec_q;
        vec_ok_o = (state_q == ST_GIVE);
    end

    assert_set_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && |(set_i & ~clr_i)) |=> req_o);
    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&clr_i) |=> !req_o);
    assert_single_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && $countones(pend_q) == 1 && set_i == '0) |=> !req_o);
    assert_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_o) |=> (vec_o[2:0] == 3'(OFFSET) && vec_o >= VEC_W'(BASE)));
    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !req_o) |=> vec_o == '0);
    assert_valid_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_ok_o);
    assert_valid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_ok_o);
    assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(vec_o));
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
    parameter int LINES = 16,
    parameter int VEC_W = 9,
    parameter int BASE  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rx_set,
    input  logic [LINES-1:0] rx_clr,
    input  logic             rx_ack,
    input  logic [LINES-1:0] tx_set,
    input  logic [LINES-1:0] tx_clr,
    input  logic             tx_ack,
    output logic             rx_req,
    output logic [VEC_W-1:0] rx_vec,
    output logic             rx_vec_ok,
    output logic             tx_req,
    output logic [VEC_W-1:0] tx_vec,
    output logic             tx_vec_ok
);
    localparam int SPAN = 8 * LINES;

    initial begin
        assert_base_aligned: assert (BASE % SPAN == 0);
    end

    vec_irq_group #(.LINES(LINES), .VEC_W(VEC_W), .BASE(BASE), .OFFSET(0)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (rx_set),
        .clr_i    (rx_clr),
        .ack_i    (rx_ack),
        .req_o    (rx_req),
        .vec_o    (rx_vec),
        .vec_ok_o (rx_vec_ok)
    );

    vec_irq_group #(.LINES(LINES), .VEC_W(VEC_W), .BASE(BASE), .OFFSET(4)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tx_set),
        .clr_i    (tx_clr),
        .ack_i    (tx_ack),
        .req_o    (tx_req),
        .vec_o    (tx_vec),
        .vec_ok_o (tx_vec_ok)
    );

    assert_groups_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ack && tx_set == '0 && tx_clr == '0) |=> $stable(tx_req));
endmodule

// File: tb/test_vec_irq_arbiter.sv
module test_vec_irq_arbiter;
    localparam int LINES = 16;
    localparam int VEC_W = 9;
    localparam int BASE  = 256;
    localparam int NPAT  = 6;
    localparam logic [LINES-1:0] PAT [NPAT] = '{16'h0001, 16'h8000, 16'hFFFF,
                                                16'h0A00, 16'h8080, 16'h0006};
    localparam int LOW [NPAT] = '{0, 15, 0, 9, 7, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LINES-1:0] rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
    logic rx_ack = 1'b0, tx_ack = 1'b0;
    logic rx_req, tx_req, rx_vec_ok, tx_vec_ok;
    logic [VEC_W-1:0] rx_vec, tx_vec;
    int n_run = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vec_irq_arbiter #(.LINES(LINES), .VEC_W(VEC_W), .BASE(BASE)) i_vec_irq_arbiter (
        .clk(clk), .rst_n(rst_n),
        .rx_set(rx_set), .rx_clr(rx_clr), .rx_ack(rx_ack),
        .tx_set(tx_set), .tx_clr(tx_clr), .tx_ack(tx_ack),
        .rx_req(rx_req), .rx_vec(rx_vec), .rx_vec_ok(rx_vec_ok),
        .tx_req(tx_req), .tx_vec(tx_vec), .tx_vec_ok(tx_vec_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
        rx_ack = 1'b0; tx_ack = 1'b0;
    endtask

    task automatic clear_all();
        rx_clr = '1; tx_clr = '1;
        step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R11 reset state
        chk("R11 rx_req", int'(rx_req), 0);
        chk("R11 tx_req", int'(tx_req), 0);
        chk("R11 valid", int'(rx_vec_ok | tx_vec_ok), 0);
        chk("R11 vec", int'(rx_vec) + int'(tx_vec), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NPAT; k++) begin
            rx_set = PAT[k]; tx_set = PAT[k];
            step();
            chk("R1 rx_req after set", int'(rx_req), 1);
            rx_ack = 1'b1; tx_ack = 1'b1;
            step();
            chk("R5 rx vector", int'(rx_vec), BASE + 8 * LOW[k]);
            chk("R6 tx vector", int'(tx_vec), BASE + 8 * LOW[k] + 4);
            chk("R8 valid after ack", int'(rx_vec_ok & tx_vec_ok), 1);
            chk("R3 req keeps others", int'(rx_req),
                int'(|(PAT[k] & ~(16'(1) << LOW[k]))));
            step();
            chk("R8 valid drops", int'(rx_vec_ok | tx_vec_ok), 0);
            clear_all();
            chk("R2 clear all", int'(rx_req | tx_req), 0);
        end

        // R7 acknowledge on empty group
        rx_ack = 1'b1;
        step();
        chk("R7 empty vector", int'(rx_vec), 0);
        chk("R7 empty valid", int'(rx_vec_ok), 1);

        // R2 set and clear on same line
        rx_set = 16'h0010; rx_clr = 16'h0010;
        step();
        chk("R2 clear wins", int'(rx_req), 0);

        // R4 / R9 drain while new sets arrive
        rx_set = 16'h0028;
        step();
        rx_ack = 1'b1; rx_set = 16'h0002;
        step();
        chk("R4 first lowest", int'(rx_vec), BASE + 8 * 3);
        rx_ack = 1'b1;
        step();
        chk("R9 kept set line 1", int'(rx_vec), BASE + 8 * 1);
        rx_ack = 1'b1;
        step();
        chk("R4 then line 5", int'(rx_vec), BASE + 8 * 5);
        chk("R4 drained", int'(rx_req), 0);

        // R10 group independence
        rx_set = 16'h0100;
        step();
        tx_ack = 1'b1;
        step();
        chk("R10 tx empty vec", int'(tx_vec), 0);
        chk("R10 rx untouched", int'(rx_req), 1);
        chk("R10 rx no valid", int'(rx_vec_ok), 0);
        rx_ack = 1'b1;
        step();
        chk("R10 rx line 8", int'(rx_vec), BASE + 8 * 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule